// File: doc/BRIEF.md
# GPIO Interrupt Summary and End-of-Interrupt Controller

This block gathers the pending flags of a bank of GPIO pins into a compact summary word and drives one interrupt line towards the host. Pins are grouped four at a time. Each group sets one summary bit. The summary is read as two 32-bit words. A small control register holds three things: a configuration for blanking status after debounce changes, an enable for that blanking, and a write-only end-of-interrupt strobe.

The interrupt line is controlled by a two-state machine. In `IRQ_QUIET` the line is low. The transition *raise* moves it to `IRQ_RAISED` in the cycle after any summary bit is seen set. In `IRQ_RAISED` the line stays high until software writes the end-of-interrupt strobe. The transition *acknowledge* then returns it to `IRQ_QUIET`. If a summary bit is still set, the line rises again one cycle later.

A second two-state machine handles status blanking. In `BLK_OFF` status is generated normally. The transition *arm* goes to `BLK_RUN` when blanking is enabled, a debounce configuration write occurs, and the programmed length is nonzero. In `BLK_RUN` a down-counter is loaded with the length and counts RTC ticks. The transition *reload* restarts the count on a further debounce write. The transition *expire* returns to `BLK_OFF` on the last tick. The transition *abort* returns to `BLK_OFF` when the enable is cleared. While in `BLK_RUN`, all summary bits are held at zero, and the interrupt-enable readback qualifier is low.

Top module: `gpio_irq_summary`

## Requirements
- R1: Summary bit n equals the OR of pin_pend[4n] through pin_pend[4n+3]. It appears one clock after the pins, provided no blanking window was active in the cycle the pins were sampled.
- R2: Summary bits 0 to 31 appear on sum_lo[31:0]. Summary bits 32 to 45 appear on sum_hi[13:0].
- R3: sum_hi[31:14] always reads 0.
- R4: irq_o rises one clock after any summary bit is set while irq_o is low. It then stays high until an end-of-interrupt write.
- R5: A control write with mst_wdata[13]=1 is an end-of-interrupt. It drops irq_o on the next clock. irq_o rises again one clock later if a summary bit is still set. Bit 13 of mst_rdata always reads 0.
- R6: A control write stores mst_wdata[11:0] as the blanking length and mst_wdata[12] as the blanking enable. Both read back on mst_rdata[11:0] and mst_rdata[12] from the next clock.
- R7: A dbnc_wr pulse starts a blanking window, shown by ien_rd_en=0 from the next clock. This happens only when the enable is 1 and the length is nonzero. The window ends on the clock of the length-th rtc_tick. With the enable at 0, or the length at 0, dbnc_wr has no effect.
- R8: While a window is active, every summary bit is forced to 0 and ien_rd_en is 0.
- R9: A dbnc_wr pulse during an active window reloads the remaining count to the full length.
- R10: Clearing the enable during a window ends the window one clock after the write.
- R11: After reset, irq_o=0, both summary words are 0, mst_rdata=0 and ien_rd_en=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_pend | input | 184 | Per-pin pending flags (interrupt or wake) |
| rtc_tick | input | 1 | One-cycle pulse per RTC period |
| dbnc_wr | input | 1 | Pulse: some pin's debounce configuration was written |
| mst_wr | input | 1 | Control register write strobe |
| mst_wdata | input | 14 | Control write data: [11:0] length, [12] enable, [13] end-of-interrupt |
| mst_rdata | output | 14 | Control readback; bit 13 reads 0 |
| sum_lo | output | 32 | Summary bits 0..31 |
| sum_hi | output | 32 | Summary bits 32..45 in [13:0], upper bits 0 |
| irq_o | output | 1 | Interrupt line to the host |
| ien_rd_en | output | 1 | Low while blanking; qualifies interrupt-enable readback |

## Verification
The bound checker watches several properties on every cycle:
- the unused high summary bits stay at zero;
- the line holds and drops around end-of-interrupt writes;
- irq_o only rises after a nonzero summary;
- every summary bit is zero during blanking;
- the window starts, and ends when the enable is cleared.

Some behaviour can only be shown by the bench's scenarios. This covers the exact window length in RTC ticks, a reload that stretches the window, the mapping of specific pins to summary bit positions, and the re-raise that follows an end-of-interrupt while a pin is still pending.

// File: rtl/gpsum_pkg.sv
package gpsum_pkg;

    typedef enum logic [0:0] {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_t;

    typedef enum logic [0:0] {
        BLK_OFF = 1'b0,
        BLK_RUN = 1'b1
    } blk_state_t;

endpackage

// File: rtl/gpsum_reduce.sv
module gpsum_reduce #(
    parameter int NUM_PINS = 184,
    parameter int GRP_SIZE = 4,
    parameter int NUM_GRP  = 46,
    parameter int SUM_W    = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_pend,
    input  logic                blank,
    output logic [SUM_W-1:0]    sum_q
);

    logic [SUM_W-1:0] grp_or;

    for (genvar g = 0; g < SUM_W; g++) begin : g_grp
        if (g < NUM_GRP) begin : g_used
            logic [GRP_SIZE-1:0] members;
            for (genvar m = 0; m < GRP_SIZE; m++) begin : g_mem
                if (g * GRP_SIZE + m < NUM_PINS) begin : g_pin
                    assign members[m] = pin_pend[g*GRP_SIZE+m];
                end else begin : g_pad
                    assign members[m] = 1'b0;
                end
            end
            assign grp_or[g] = |members;
        end else begin : g_unused
            assign grp_or[g] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (blank) begin
            sum_q <= '0;
        end else begin
            sum_q <= grp_or;
        end
    end

endmodule

// File: rtl/gpsum_blank.sv
module gpsum_blank
    import gpsum_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_en,
    input  logic [LEN_W-1:0] blk_len,
    input  logic             dbnc_wr,
    input  logic             rtc_tick,
    output logic             blank
);

    blk_state_t       state, state_n;
    logic [LEN_W-1:0] cnt, cnt_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= BLK_OFF;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            BLK_OFF: begin
                if (blk_en && dbnc_wr && (blk_len != '0)) begin
                    state_n = BLK_RUN;          // arm
                    cnt_n   = blk_len;
                end
            end
            BLK_RUN: begin
                if (!blk_en) begin
                    state_n = BLK_OFF;          // abort
                end else if (dbnc_wr) begin
                    if (blk_len == '0) begin
                        state_n = BLK_OFF;
                    end else begin
                        cnt_n = blk_len;        // reload
                    end
                end else if (rtc_tick) begin
                    if (cnt <= LEN_W'(1)) begin
                        state_n = BLK_OFF;      // expire
                    end else begin
                        cnt_n = cnt - LEN_W'(1);
                    end
                end
            end
            default: state_n = BLK_OFF;
        endcase
    end

    always_comb begin
        blank = (state == BLK_RUN);
    end

endmodule

// File: rtl/gpsum_irq.sv
module gpsum_irq
    import gpsum_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_pend,
    input  logic eoi,
    output logic irq_o
);

    irq_state_t state, state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= IRQ_QUIET;
        end else begin
            state <= state_n;
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            IRQ_QUIET:  if (any_pend) state_n = IRQ_RAISED;  // raise
            IRQ_RAISED: if (eoi)      state_n = IRQ_QUIET;   // acknowledge
            default:                  state_n = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq_o = (state == IRQ_RAISED);
    end

endmodule

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary #(
    parameter int NUM_PINS = 184,
    parameter int GRP_SIZE = 4,
    parameter int LEN_W    = 12,
    parameter int REG_W    = 32,
    localparam int CTRL_W  = LEN_W + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_pend,
    input  logic                rtc_tick,
    input  logic                dbnc_wr,
    input  logic                mst_wr,
    input  logic [CTRL_W-1:0]   mst_wdata,
    output logic [CTRL_W-1:0]   mst_rdata,
    output logic [REG_W-1:0]    sum_lo,
    output logic [REG_W-1:0]    sum_hi,
    output logic                irq_o,
    output logic                ien_rd_en
);

    localparam int NUM_GRP = (NUM_PINS + GRP_SIZE - 1) / GRP_SIZE;
    localparam int SUM_W   = 2 * REG_W;
    localparam int EN_BIT  = LEN_W;
    localparam int EOI_BIT = LEN_W + 1;

    logic [LEN_W-1:0] blk_len;
    logic             blk_en;
    logic             eoi;
    logic             blank;
    logic [SUM_W-1:0] sum_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_len <= '0;
            blk_en  <= 1'b0;
        end else if (mst_wr) begin
            blk_len <= mst_wdata[LEN_W-1:0];
            blk_en  <= mst_wdata[EN_BIT];
        end
    end

    always_comb begin
        eoi       = mst_wr & mst_wdata[EOI_BIT];
        mst_rdata = {1'b0, blk_en, blk_len};
        sum_lo    = sum_q[REG_W-1:0];
        sum_hi    = sum_q[SUM_W-1:REG_W];
        ien_rd_en = ~blank;
    end

    gpsum_reduce #(
        .NUM_PINS (NUM_PINS),
        .GRP_SIZE (GRP_SIZE),
        .NUM_GRP  (NUM_GRP),
        .SUM_W    (SUM_W)
    ) u_reduce (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_pend (pin_pend),
        .blank    (blank),
        .sum_q    (sum_q)
    );

    gpsum_blank #(
        .LEN_W (LEN_W)
    ) u_blank (
        .clk      (clk),
        .rst_n    (rst_n),
        .blk_en   (blk_en),
        .blk_len  (blk_len),
        .dbnc_wr  (dbnc_wr),
        .rtc_tick (rtc_tick),
        .blank    (blank)
    );

    gpsum_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_pend (|sum_q),
        .eoi      (eoi),
        .irq_o    (irq_o)
    );

endmodule

// File: rtl/gpio_irq_summary_chk.sv
module gpio_irq_summary_chk #(
    parameter int HI_USED = 14
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mst_wr,
    input logic [13:0] mst_wdata,
    input logic [13:0] mst_rdata,
    input logic        dbnc_wr,
    input logic [31:0] sum_lo,
    input logic [31:0] sum_hi,
    input logic        irq_o,
    input logic        ien_rd_en
);

    p_hi_unused_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sum_hi[31:HI_USED] == '0);

    p_irq_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(mst_wr && mst_wdata[13])) |=> irq_o);

    p_rise_needs_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past((sum_lo != '0) || (sum_hi != '0)));

    p_eoi_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && mst_wr && mst_wdata[13]) |=> !irq_o);

    p_cfg_readback_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mst_wr |=> (mst_rdata[12:0] == $past(mst_wdata[12:0])));

    p_window_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_rdata[12] && dbnc_wr && (mst_rdata[11:0] != '0)) |=> !ien_rd_en);

    p_blank_zero_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_rd_en |=> ((sum_lo == '0) && (sum_hi == '0)));

    p_disable_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mst_rdata[12] |=> ien_rd_en);

endmodule

bind gpio_irq_summary gpio_irq_summary_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mst_wr    (mst_wr),
    .mst_wdata (mst_wdata),
    .mst_rdata (mst_rdata),
    .dbnc_wr   (dbnc_wr),
    .sum_lo    (sum_lo),
    .sum_hi    (sum_hi),
    .irq_o     (irq_o),
    .ien_rd_en (ien_rd_en)
);

// File: tb/gpio_irq_summary_bench.sv
`timescale 1ns/1ps
module gpio_irq_summary_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [183:0] pin_pend = '0;
    logic         rtc_tick = 1'b0;
    logic         dbnc_wr = 1'b0;
    logic         mst_wr = 1'b0;
    logic [13:0]  mst_wdata = '0;
    logic [13:0]  mst_rdata;
    logic [31:0]  sum_lo, sum_hi;
    logic         irq_o, ien_rd_en;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    bit model_on = 0;
    bit done = 0;

    // behavioural reference
    bit [63:0] m_sum;
    bit        m_irq, m_blank, m_en;
    int        m_cnt, m_len;

    always #10 clk = ~clk;

    gpio_irq_summary u_gpio_irq_summary (
        .clk(clk), .rst_n(rst_n), .pin_pend(pin_pend), .rtc_tick(rtc_tick),
        .dbnc_wr(dbnc_wr), .mst_wr(mst_wr), .mst_wdata(mst_wdata),
        .mst_rdata(mst_rdata), .sum_lo(sum_lo), .sum_hi(sum_hi),
        .irq_o(irq_o), .ien_rd_en(ien_rd_en)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sum = '0; m_irq = 0; m_blank = 0; m_en = 0; m_cnt = 0; m_len = 0;
        end else begin
            bit [63:0] nsum;
            bit nirq, nblank, eoi;
            int ncnt;
            nsum = '0;
            for (int g = 0; g < 46; g++)
                for (int m = 0; m < 4; m++)
                    if (pin_pend[4*g+m]) nsum[g] = 1'b1;
            if (m_blank) nsum = '0;
            eoi  = mst_wr && mst_wdata[13];
            nirq = m_irq ? !eoi : (m_sum != 0);
            nblank = m_blank;
            ncnt = m_cnt;
            if (!m_blank) begin
                if (m_en && dbnc_wr && m_len != 0) begin nblank = 1; ncnt = m_len; end
            end else if (!m_en) nblank = 0;
            else if (dbnc_wr) begin
                if (m_len == 0) nblank = 0; else ncnt = m_len;
            end else if (rtc_tick) begin
                if (m_cnt <= 1) nblank = 0; else ncnt = m_cnt - 1;
            end
            if (mst_wr) begin m_len = int'(mst_wdata[11:0]); m_en = mst_wdata[12]; end
            m_sum = nsum; m_irq = nirq; m_blank = nblank; m_cnt = ncnt;
        end
    end

    always @(negedge clk) begin
        if (model_on && rst_n) begin
            chk("R1 sum_lo", 64'(sum_lo), 64'(m_sum[31:0]));
            chk("R2 sum_hi", 64'(sum_hi), 64'(m_sum[63:32]));
            chk("R4 irq_o", 64'(irq_o), 64'(m_irq));
            chk("R6 mst_rdata", 64'(mst_rdata), 64'({1'b0, m_en, 12'(m_len)}));
            chk("R8 ien_rd_en", 64'(ien_rd_en), 64'(!m_blank));
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
            summary();
            $finish;
        end
    end

    task automatic nx(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_mst(input logic [13:0] d);
        mst_wr = 1'b1; mst_wdata = d;
        nx();
        mst_wr = 1'b0; mst_wdata = '0;
    endtask

    task automatic pulse_dbnc();
        dbnc_wr = 1'b1; nx(); dbnc_wr = 1'b0;
    endtask

    task automatic pulse_tick();
        rtc_tick = 1'b1; nx(); rtc_tick = 1'b0;
    endtask

    task automatic quiesce(input logic [13:0] cfg);
        pin_pend = '0;
        nx(2);
        wr_mst(cfg | 14'h2000);
        nx(2);
    endtask

    initial begin
        nx(3);
        rst_n = 1'b1;
        model_on = 1;
        nx();
        chk("R11 irq", 64'(irq_o), 64'd0);
        chk("R11 sum", {sum_hi, sum_lo}, 64'd0);
        chk("R11 rdata", 64'(mst_rdata), 64'd0);
        chk("R11 ien", 64'(ien_rd_en), 64'd1);

        // group mapping and raise
        pin_pend[5] = 1'b1;
        nx();
        chk("R1 pin5->bit1", 64'(sum_lo), 64'h2);
        chk("R4 not yet", 64'(irq_o), 64'd0);
        nx();
        chk("R4 raised", 64'(irq_o), 64'd1);
        nx(3);
        chk("R4 held", 64'(irq_o), 64'd1);
        wr_mst(14'h2000);
        chk("R5 eoi drop", 64'(irq_o), 64'd0);
        nx();
        chk("R5 rearm", 64'(irq_o), 64'd1);
        pin_pend = '0;
        wr_mst(14'h2000);
        chk("R5 eoi drop 2", 64'(irq_o), 64'd0);
        nx(2);
        chk("R5 stays low", 64'(irq_o), 64'd0);

        // high word split
        pin_pend[183] = 1'b1; pin_pend[128] = 1'b1; pin_pend[3] = 1'b1;
        nx();
        chk("R2 hi bits", 64'(sum_hi), 64'h2001);
        chk("R2 lo bit0", 64'(sum_lo), 64'h1);
        chk("R3 hi upper", 64'(sum_hi[31:14]), 64'd0);
        quiesce(14'h0000);

        // config readback, eoi reads zero
        wr_mst(14'h3003);
        chk("R6 readback", 64'(mst_rdata), 64'h1003);
        chk("R5 eoi reads 0", 64'(mst_rdata[13]), 64'd0);

        // window of 3 ticks
        pulse_dbnc();
        chk("R7 window on", 64'(ien_rd_en), 64'd0);
        pin_pend[0] = 1'b1;
        nx();
        chk("R8 sums blanked", {sum_hi, sum_lo}, 64'd0);
        pulse_tick(); pulse_tick();
        chk("R7 two ticks", 64'(ien_rd_en), 64'd0);
        chk("R8 still blank", 64'(irq_o), 64'd0);
        pulse_tick();
        chk("R7 window off", 64'(ien_rd_en), 64'd1);
        nx();
        chk("R1 after window", 64'(sum_lo), 64'h1);
        quiesce(14'h1003);

        // reload
        pulse_dbnc();
        pulse_tick(); pulse_tick();
        pulse_dbnc();
        chk("R9 reload", 64'(ien_rd_en), 64'd0);
        pulse_tick(); pulse_tick();
        chk("R9 stretched", 64'(ien_rd_en), 64'd0);
        pulse_tick();
        chk("R9 ends", 64'(ien_rd_en), 64'd1);

        // disabling aborts
        pulse_dbnc();
        chk("R10 window on", 64'(ien_rd_en), 64'd0);
        wr_mst(14'h0003);
        nx();
        chk("R10 aborted", 64'(ien_rd_en), 64'd1);
        pulse_dbnc();
        chk("R7 enable off ignored", 64'(ien_rd_en), 64'd1);
        wr_mst(14'h1000);
        pulse_dbnc();
        chk("R7 zero length ignored", 64'(ien_rd_en), 64'd1);

        // random traffic against the reference
        for (int i = 0; i < 3000; i++) begin
            pin_pend = '0;
            if ($urandom % 3 == 0) pin_pend[$urandom % 184] = 1'b1;
            rtc_tick = ($urandom % 4 == 0);
            dbnc_wr  = ($urandom % 40 == 0);
            mst_wr   = ($urandom % 30 == 0);
            mst_wdata = {1'($urandom), 1'($urandom), 9'd0, 3'($urandom)};
            nx();
        end
        pin_pend = '0; rtc_tick = 0; dbnc_wr = 0; mst_wr = 0;
        nx(2);
        summary();
        $finish;
    end

endmodule